// File: doc/BRIEF.md
# Boot Vector Remap Decoder

This block decodes processor addresses for a small microcontroller memory map and decides where the lowest region of the map, which holds the exception vectors (addresses 0x00 to 0x20), is served from. After reset that region belongs to the boot device on external chip select 0. Once software sets the remap control bit, the same low region is served by internal SRAM. This lets software install its own vector table in RAM.

The remap can only be set. Clearing it takes a reset. Until it is set, external chip selects 1 to 7 stay blocked, and an access to one of those banks is reported as a miss. While reset is held, a boot strap input is sampled. It tells the boot memory interface whether the boot device is 8 or 16 bits wide. Once reset is released, the strap is ignored, so the pin can serve as a general I/O line.

All decode outputs are registered and appear one clock after the request is presented.

Top module: `vector_remap_dec`

## Requirements
- R1: While reset is high, at the next clock edge all select outputs, `miss_o` and `remap_o` become 0.
- R2: Before the remap, a valid access with an address below 0x0010_0000 asserts `boot_sel_o` and `cs_o[0]` and does not assert `sram_sel_o`.
- R3: A cycle with `cfg_we_i`=1 and `cfg_wdata_i`=1 sets the remap state. `remap_o` reads 1 from the next cycle on, and low addresses below 0x0010_0000 then assert `sram_sel_o` only.
- R4: A cycle with `cfg_we_i`=1 and `cfg_wdata_i`=0 leaves the remap state unchanged, whether it is set or clear.
- R5: Once set, the remap state stays set until reset is applied, and reset returns it to 0.
- R6: The external banks at 0x0050_0000 + (i-1)·0x0010_0000 for i = 1..7 drive `cs_o[i]` only after the remap. Before the remap, such an access asserts `miss_o` and no select.
- R7: The external bank at 0x0040_0000..0x004F_FFFF drives `cs_o[0]`, both before and after the remap.
- R8: Addresses 0x0010_0000..0x001F_FFFF always select internal SRAM (`sram_sel_o`).
- R9: `boot_8bit_o` equals the strap value sampled at the last clock edge with reset high (1 = 8-bit boot device, 0 = 16-bit). Strap changes after reset has no effect.
- R10: A valid access outside every region (for example 0x0020_0000 or 0x0100_0000) asserts only `miss_o`. With `bus_valid_i`=0, every select output and `miss_o` are 0.
- R11: The decode result for a request presented in one cycle appears on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (internal or pin reset) |
| bus_valid_i | input | 1 | Processor access strobe |
| bus_addr_i | input | ADDR_W | Processor byte address |
| cfg_we_i | input | 1 | Write strobe for the remap control bit |
| cfg_wdata_i | input | 1 | Remap command bit value |
| boot_strap_i | input | 1 | Boot width strap, sampled during reset |
| remap_o | output | 1 | Current remap state (register read-back) |
| boot_8bit_o | output | 1 | Latched boot width, 1 = 8-bit |
| boot_sel_o | output | 1 | Boot memory serves the access |
| sram_sel_o | output | 1 | Internal SRAM serves the access |
| cs_o | output | NUM_CS | External chip selects |
| miss_o | output | 1 | Access was blocked or unmapped |

## Verification
The bench sends the same address set twice: once before the remap and once after it. A low vector address tells boot memory apart from SRAM. Addresses in banks 1 and 7 show whether the chip-select gating works, and the bank 0 and SRAM alias addresses show that those regions ignore the remap state. Zero writes, interleaved both before and after a one-write, separate a sticky flag from a plain register. Two resets with opposite strap values, with the strap flipped as reset ends, show whether the strap is sampled at the right moment.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic {
    BOOT_W16 = 1'b0,
    BOOT_W8  = 1'b1
  } boot_width_e;

  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_NUM_CS     = 8;
  localparam int unsigned DEF_LOW_SHIFT  = 20;
  localparam int unsigned DEF_SRAM_SHIFT = 20;
  localparam int unsigned DEF_BANK_SHIFT = 20;
  localparam logic [31:0] DEF_SRAM_BASE  = 32'h0010_0000;
  localparam logic [31:0] DEF_EXT_BASE   = 32'h0040_0000;
endpackage

// File: rtl/remap_state.sv
module remap_state
  import remap_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we_i,
  input  logic        cfg_wdata_i,
  input  logic        boot_strap_i,
  output logic        remap_q_o,
  output boot_width_e boot_w_o
);
  logic        remap_q;
  boot_width_e width_q;

  // One-way flag: only a written one changes it, only reset clears it.
  always_ff @(posedge clk) begin
    if (rst)
      remap_q <= 1'b0;
    else if (cfg_we_i && cfg_wdata_i)
      remap_q <= 1'b1;
  end

  // The strap is followed while reset is held and frozen afterwards.
  always_ff @(posedge clk) begin
    if (rst)
      width_q <= boot_width_e'(boot_strap_i);
  end

  assign remap_q_o = remap_q;
  assign boot_w_o  = width_q;
endmodule

// File: rtl/remap_addr_decode.sv
module remap_addr_decode #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_CS     = 8,
  parameter int unsigned LOW_SHIFT  = 20,
  parameter int unsigned SRAM_SHIFT = 20,
  parameter int unsigned BANK_SHIFT = 20,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] EXT_BASE  = 32'h0040_0000
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              remap_i,
  output logic              boot_o,
  output logic              sram_o,
  output logic [NUM_CS-1:0] cs_o,
  output logic              miss_o
);
  localparam logic [ADDR_W:0] SRAM_LO = {1'b0, SRAM_BASE};
  localparam logic [ADDR_W:0] SRAM_HI = SRAM_LO + ((ADDR_W+1)'(1) << SRAM_SHIFT);

  logic              in_low;
  logic              in_sram;
  logic              ext_ge;
  logic [ADDR_W-1:0] ext_off;
  logic [ADDR_W-1:0] ext_bank;
  logic [NUM_CS-1:0] bank_hit;
  logic [NUM_CS-1:0] cs_raw;

  always_comb begin
    in_low   = (addr_i >> LOW_SHIFT) == '0;
    in_sram  = ({1'b0, addr_i} >= SRAM_LO) && ({1'b0, addr_i} < SRAM_HI);
    ext_ge   = addr_i >= EXT_BASE;
    ext_off  = addr_i - EXT_BASE;
    ext_bank = ext_off >> BANK_SHIFT;
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_bank
    assign bank_hit[i] = ext_ge && (ext_bank == ADDR_W'(i));
    if (i == 0) begin : g_cs0
      // Bank 0 is always reachable and also carries the boot device.
      assign cs_raw[i] = valid_i && (bank_hit[i] || (in_low && !remap_i));
    end else begin : g_csn
      assign cs_raw[i] = valid_i && bank_hit[i] && remap_i;
    end
  end

  assign boot_o = valid_i && in_low && !remap_i;
  assign sram_o = valid_i && ((in_low && remap_i) || in_sram);
  assign cs_o   = cs_raw;
  assign miss_o = valid_i && !((|cs_raw) || sram_o);
endmodule

// File: rtl/remap_out_reg.sv
module remap_out_reg #(
  parameter int unsigned NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_d,
  input  logic              sram_d,
  input  logic [NUM_CS-1:0] cs_d,
  input  logic              miss_d,
  output logic              boot_q,
  output logic              sram_q,
  output logic [NUM_CS-1:0] cs_q,
  output logic              miss_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      boot_q <= 1'b0;
      sram_q <= 1'b0;
      cs_q   <= '0;
      miss_q <= 1'b0;
    end else begin
      boot_q <= boot_d;
      sram_q <= sram_d;
      cs_q   <= cs_d;
      miss_q <= miss_d;
    end
  end
endmodule

// File: rtl/vector_remap_dec.sv
module vector_remap_dec
  import remap_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned NUM_CS     = DEF_NUM_CS,
  parameter int unsigned LOW_SHIFT  = DEF_LOW_SHIFT,
  parameter int unsigned SRAM_SHIFT = DEF_SRAM_SHIFT,
  parameter int unsigned BANK_SHIFT = DEF_BANK_SHIFT,
  parameter logic [ADDR_W-1:0] SRAM_BASE = ADDR_W'(DEF_SRAM_BASE),
  parameter logic [ADDR_W-1:0] EXT_BASE  = ADDR_W'(DEF_EXT_BASE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              cfg_we_i,
  input  logic              cfg_wdata_i,
  input  logic              boot_strap_i,
  output logic              remap_o,
  output logic              boot_8bit_o,
  output logic              boot_sel_o,
  output logic              sram_sel_o,
  output logic [NUM_CS-1:0] cs_o,
  output logic              miss_o
);
  logic              remap_q;
  boot_width_e       boot_w;
  logic              dec_boot;
  logic              dec_sram;
  logic [NUM_CS-1:0] dec_cs;
  logic              dec_miss;

  remap_state u_state (
    .clk          (clk),
    .rst          (rst),
    .cfg_we_i     (cfg_we_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .boot_strap_i (boot_strap_i),
    .remap_q_o    (remap_q),
    .boot_w_o     (boot_w)
  );

  remap_addr_decode #(
    .ADDR_W     (ADDR_W),
    .NUM_CS     (NUM_CS),
    .LOW_SHIFT  (LOW_SHIFT),
    .SRAM_SHIFT (SRAM_SHIFT),
    .BANK_SHIFT (BANK_SHIFT),
    .SRAM_BASE  (SRAM_BASE),
    .EXT_BASE   (EXT_BASE)
  ) u_dec (
    .valid_i (bus_valid_i),
    .addr_i  (bus_addr_i),
    .remap_i (remap_q),
    .boot_o  (dec_boot),
    .sram_o  (dec_sram),
    .cs_o    (dec_cs),
    .miss_o  (dec_miss)
  );

  remap_out_reg #(.NUM_CS(NUM_CS)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .boot_d (dec_boot),
    .sram_d (dec_sram),
    .cs_d   (dec_cs),
    .miss_d (dec_miss),
    .boot_q (boot_sel_o),
    .sram_q (sram_sel_o),
    .cs_q   (cs_o),
    .miss_q (miss_o)
  );

  assign remap_o     = remap_q;
  assign boot_8bit_o = (boot_w == BOOT_W8);
endmodule

// File: rtl/remap_dec_checker.sv
module remap_dec_checker #(
  parameter int unsigned NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we_i,
  input logic              cfg_wdata_i,
  input logic              remap_o,
  input logic              boot_8bit_o,
  input logic              boot_sel_o,
  input logic              sram_sel_o,
  input logic [NUM_CS-1:0] cs_o,
  input logic              miss_o
);
  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && cfg_wdata_i) |=> remap_o);

  p_zero_write_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i && !cfg_wdata_i && !remap_o) |=> !remap_o);

  p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    remap_o |=> remap_o);

  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (cs_o[NUM_CS-1:1] != '0) |-> remap_o);

  p_boot_on_cs0_r2: assert property (@(posedge clk) disable iff (rst)
    boot_sel_o |-> (cs_o[0] && !sram_sel_o));

  p_one_target_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sram_sel_o, cs_o, miss_o}));

  p_strap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(boot_8bit_o));
endmodule

bind vector_remap_dec remap_dec_checker #(.NUM_CS(NUM_CS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .remap_o     (remap_o),
  .boot_8bit_o (boot_8bit_o),
  .boot_sel_o  (boot_sel_o),
  .sram_sel_o  (sram_sel_o),
  .cs_o        (cs_o),
  .miss_o      (miss_o)
);

// File: tb/vector_remap_dec_bench.sv
module vector_remap_dec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NCS = 8;

  typedef struct {
    int          cyc;
    logic        boot;
    logic        sram;
    logic [NCS-1:0] cs;
    logic        miss;
    logic [AW-1:0] addr;
    string       req;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic cfg_we = 1'b0;
  logic cfg_wdata = 1'b0;
  logic strap = 1'b1;
  logic remap_o, boot_8bit_o, boot_sel_o, sram_sel_o, miss_o;
  logic [NCS-1:0] cs_o;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;
  logic remap_m = 1'b0;
  item_t sb[$];

  vector_remap_dec u_vector_remap_dec (
    .clk(clk), .rst(rst), .bus_valid_i(bus_valid), .bus_addr_i(bus_addr),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .boot_strap_i(strap),
    .remap_o(remap_o), .boot_8bit_o(boot_8bit_o), .boot_sel_o(boot_sel_o),
    .sram_sel_o(sram_sel_o), .cs_o(cs_o), .miss_o(miss_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected decode, taken from the memory map in the requirements.
  task automatic access(logic [AW-1:0] a, string req);
    item_t it;
    logic lo, sr, ge;
    logic [AW-1:0] bank;
    it.cyc = cyc; it.addr = a; it.req = req;
    it.cs = '0;
    lo = a < 32'h0010_0000;
    sr = (a >= 32'h0010_0000) && (a < 32'h0020_0000);
    ge = a >= 32'h0040_0000;
    bank = (a - 32'h0040_0000) >> 20;
    it.boot = lo && !remap_m;
    it.sram = (lo && remap_m) || sr;
    if (lo && !remap_m) it.cs[0] = 1'b1;
    if (ge && bank == 0) it.cs[0] = 1'b1;
    if (ge && bank > 0 && bank < NCS && remap_m) it.cs[bank] = 1'b1;
    it.miss = !(it.sram || (it.cs != '0));
    bus_valid = 1'b1; bus_addr = a;
    sb.push_back(it);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic idle_check(string req);
    item_t it;
    it.cyc = cyc; it.addr = bus_addr; it.req = req;
    it.boot = 0; it.sram = 0; it.cs = '0; it.miss = 0;
    bus_valid = 1'b0;
    bus_addr = 32'h0000_0004;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic cfg_write(logic v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = 1'b0;
    if (v) remap_m = 1'b1;
  endtask

  task automatic do_reset(logic s);
    rst = 1'b1; strap = s;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 sel", {28'b0, boot_sel_o, sram_sel_o, miss_o, remap_o}, 32'h0);
    check("R1 cs", {24'b0, cs_o}, 32'h0);
    rst = 1'b0; strap = ~s;
    remap_m = 1'b0;
    @(negedge clk);
    check("R9 strap latched", {31'b0, boot_8bit_o}, {31'b0, s});
  endtask

  // Monitor: compares items one edge after they were presented (R11).
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].cyc < cyc) begin
      item_t it;
      it = sb.pop_front();
      check({it.req, " boot"}, {31'b0, boot_sel_o}, {31'b0, it.boot});
      check({it.req, " sram"}, {31'b0, sram_sel_o}, {31'b0, it.sram});
      check({it.req, " cs"}, {24'b0, cs_o}, {24'b0, it.cs});
      check({it.req, " miss"}, {31'b0, miss_o}, {31'b0, it.miss});
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(1'b1);
    strap = 1'b1;
    access(32'h0000_0000, "R2 vec0");
    access(32'h0000_001C, "R2 vec1c");
    access(32'h0050_0000, "R6 cs1 blocked");
    access(32'h00B0_0010, "R6 cs7 blocked");
    access(32'h0040_0100, "R7 cs0 bank");
    access(32'h0010_0020, "R8 sram alias");
    access(32'h0020_0000, "R10 hole");
    access(32'h0100_0000, "R10 above");
    idle_check("R10 idle");
    cfg_write(1'b0);
    check("R4 zero write pre", {31'b0, remap_o}, 32'h0);
    access(32'h0000_0008, "R4 still boot");
    cfg_write(1'b1);
    check("R3 readback", {31'b0, remap_o}, 32'h1);
    access(32'h0000_0000, "R3 vec sram");
    access(32'h0000_0020, "R3 vec20 sram");
    access(32'h0050_0000, "R6 cs1 open");
    access(32'h00B0_FFFC, "R6 cs7 open");
    access(32'h0080_0000, "R6 cs4 open");
    access(32'h0040_0000, "R7 cs0 after");
    access(32'h001F_FFFC, "R8 sram after");
    access(32'h00C0_0000, "R10 past banks");
    cfg_write(1'b0);
    check("R4 zero write post", {31'b0, remap_o}, 32'h1);
    repeat (5) @(negedge clk);
    check("R5 sticky", {31'b0, remap_o}, 32'h1);
    check("R9 strap held", {31'b0, boot_8bit_o}, 32'h1);
    do_reset(1'b0);
    check("R5 cleared by reset", {31'b0, remap_o}, 32'h0);
    access(32'h0000_0010, "R5 boot again");
    access(32'h0060_0000, "R5 cs2 blocked again");
    repeat (3) @(negedge clk);
    check("R9 16-bit boot", {31'b0, boot_8bit_o}, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule